// File: doc/BRIEF.md
# Four-Bank Programmable Skew Clock Generator

This block is a cycle-level digital model of a clock generator with four output banks of two outputs each. It runs on a fast timing clock whose period is one time unit (tU). From that clock it derives a nominal reference clock whose period is 8, 16 or 32 tU, chosen by a range select. Each bank then produces a copy of the reference that can be moved earlier or later in whole tU steps, divided down, or inverted. The setting for each bank comes from a two-digit select code.

Every select is a three-level value, pre-decoded to 2 bits: 00 = low, 01 = mid, 10 = high. The code 11 is read as mid. A sync-edge select chooses whether the outputs line up with the rising or the falling edge of the reference. A test select bypasses the skew logic, so the reference passes straight to the outputs, through the bank dividers only.

A single counter runs modulo four reference periods and drives all the timing. Every output is computed from that counter and registered. Configuration is captured only when the counter wraps, so a change in the middle of a period never cuts an output short.

Top module: `skewgen_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ref_out` and every bit of `bank_out` are 0 after that edge. The configuration inputs present at that edge are captured as the active setting.
- R2: `range_sel` 00, 01 and 10 give a reference period of 32, 16 and 8 tU, and 11 acts as 01. `ref_out` is high for the first half of each period. The internal counter wraps once every four reference periods.
- R3: Bank 1 code is `bank_code[3:0]` and bank 2 code is `bank_code[7:4]`. The upper 2 bits are the first digit. Let the code index be first*3 + second, with each digit 00=0, 01=1, 10=2, and 11 counted as 1. The output then lags the reference by (index − 4) tU, covering −4 to +4 tU. Negative values lead the reference and wrap around the period.
- R4: Bank 3 (`bank_code[11:8]`) delays by 2·(index − 4) tU for indices 1 to 7. Index 0 (LL) gives the reference divided by 2, and index 8 (HH) gives it divided by 4. Both of those have zero skew.
- R5: Bank 4 (`bank_code[15:12]`) delays by 2·(index − 4) tU for indices 1 to 7. Index 0 gives the reference divided by 2. Index 8 gives the inverted reference.
- R6: When `edge_sel` is 00, every non-bypassed output is delayed by a further half reference period, so it aligns to the falling edge of the reference. Any other value gives rising-edge alignment.
- R7: When `test_sel` is not 00, the skew codes and `edge_sel` have no effect. Banks 1 and 2 follow `ref_out`. Bank 3 divides the reference by 2 for LL, by 4 for HH, and by 1 otherwise. Bank 4 divides by 2 for LL and by 1 otherwise.
- R8: Configuration inputs take effect only on the edge at which the counter wraps. Changes at any other time leave the outputs unchanged until that wrap.
- R9: Each output is high for exactly half of its own period, and the two outputs of a bank are identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, one period per tU |
| rst_n | input | 1 | Synchronous active-low reset |
| range_sel | input | 2 | Reference period select (three-level) |
| edge_sel | input | 2 | Sync-edge select (three-level) |
| test_sel | input | 2 | Skew bypass select (three-level) |
| bank_code | input | 16 | Four 4-bit two-digit bank codes, bank 1 lowest |
| ref_out | output | 1 | Nominal reference clock |
| bank_out | output | 8 | Bank n outputs at bits 2n-2 and 2n-1 |

## Verification
On every cycle, the embedded properties check four things. The counter stays inside its four-period window. The captured configuration holds still except at a wrap. Bypassed banks 1 and 2 track the reference. Two relations hold against the reference: a falling-edge zero-skew output is its complement, and an inverted bank 4 is also its complement. The exact placement of every edge cannot be captured by those properties. That covers each skew step, the divide-by-2 and divide-by-4 phases, negative-skew wrap, and the moment a mid-period configuration change finally takes hold. The bench's cycle-accurate model shows these, across its vector table and directed runs.

// File: rtl/skewgen_pkg.sv
// Shared types and helpers for the four-bank skew generator.
// Assumes three-level selects arrive pre-decoded as 2-bit values.
package skewgen_pkg;

    localparam int BANKS  = 4;
    localparam int CODE_W = 4;

    // Bank flavours: fine 1-tU steps, coarse steps with /4, coarse with invert
    typedef enum logic [1:0] {
        KIND_FINE = 2'd0,
        KIND_DIV4 = 2'd1,
        KIND_INV  = 2'd2
    } bank_kind_t;

    // Active configuration captured at reset and at counter wrap
    typedef struct packed {
        logic [1:0]              range_sel;
        logic                    fall_sync;
        logic                    bypass;
        logic [BANKS*CODE_W-1:0] codes;
    } cfg_t;

    // Fold a three-level digit to 0/1/2, with 11 read as mid
    function automatic int digit_val(input logic [1:0] d);
        case (d)
            2'b00:   return 0;
            2'b10:   return 2;
            default: return 1;
        endcase
    endfunction

    // Two-digit code to index 0..8 (first digit weighted by 3)
    function automatic int code_index(input logic [CODE_W-1:0] c);
        return digit_val(c[3:2]) * 3 + digit_val(c[1:0]);
    endfunction

endpackage

// File: rtl/skewgen_timebase.sv
// Free-running tU counter, modulo four reference periods, plus the
// configuration register that only reloads at reset or at the wrap.
// Assumes BASE_UNITS is a power of two and CNT_W covers 16*BASE_UNITS.
module skewgen_timebase
    import skewgen_pkg::*;
#(
    parameter int BASE_UNITS = 8,
    parameter int CNT_W      = $clog2(BASE_UNITS) + 4,
    parameter int SH_W       = $clog2(CNT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_t             cfg_in,
    output logic [CNT_W-1:0] cnt,
    output cfg_t             cfg_q,
    output logic [SH_W-1:0]  per_sh
);

    localparam int BASE_SH = $clog2(BASE_UNITS);

    logic [CNT_W-1:0] last;

    // Period exponent from the captured range select
    always_comb begin
        case (cfg_q.range_sel)
            2'b00:   per_sh = SH_W'(BASE_SH + 2);
            2'b10:   per_sh = SH_W'(BASE_SH);
            default: per_sh = SH_W'(BASE_SH + 1);
        endcase
    end

    // Final count of the four-period window
    always_comb begin
        last = {CNT_W{1'b1}} >> (SH_W'(CNT_W) - per_sh - SH_W'(2));
    end

    // Counter advance and wrap-time configuration capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            cfg_q <= cfg_in;
        end else if (cnt == last) begin
            cnt   <= '0;
            cfg_q <= cfg_in;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    // R2: counter never leaves the four-period window
    a_r2_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last);

    // R8: configuration holds on every edge that is not a wrap
    a_r8_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != last) |=> $stable(cfg_q));

endmodule

// File: rtl/skewgen_bank_decode.sv
// Turns one bank's two-digit code into a phase offset, divider exponent
// and invert flag. KIND picks the bank's skew table. Assumes per_sh >= 1.
module skewgen_bank_decode
    import skewgen_pkg::*;
#(
    parameter bank_kind_t KIND  = KIND_FINE,
    parameter int         CNT_W = 7,
    parameter int         SH_W  = 3
) (
    input  logic [CODE_W-1:0] code,
    input  logic              fall_sync,
    input  logic              bypass,
    input  logic [SH_W-1:0]   per_sh,
    output logic [CNT_W-1:0]  off,
    output logic [1:0]        div_sh,
    output logic              inv
);

    // Select offset, divider and inversion for this bank
    always_comb begin
        int idx;
        int skew;
        int half;
        idx    = code_index(code);
        skew   = 0;
        half   = fall_sync ? (1 << (int'(per_sh) - 1)) : 0;
        div_sh = 2'd0;
        inv    = 1'b0;
        if (bypass) begin
            half = 0;
            if (idx == 0 && KIND != KIND_FINE) div_sh = 2'd1;
            if (idx == 8 && KIND == KIND_DIV4) div_sh = 2'd2;
        end else if (KIND == KIND_FINE) begin
            skew = idx - 4;
        end else if (idx == 0) begin
            div_sh = 2'd1;
        end else if (idx == 8) begin
            if (KIND == KIND_DIV4) div_sh = 2'd2;
            else                   inv    = 1'b1;
        end else begin
            skew = 2 * (idx - 4);
        end
        off = CNT_W'(skew + half);
    end

endmodule

// File: rtl/skewgen_phase_gen.sv
// One registered clock output: high for the first half of a window of
// 2**span_sh tU that starts off tU after counter zero. Assumes the window
// divides 2**CNT_W and span_sh >= 1.
module skewgen_phase_gen #(
    parameter int CNT_W = 7,
    parameter int SH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] off,
    input  logic [SH_W-1:0]  span_sh,
    input  logic             inv,
    output logic             q
);

    logic [CNT_W-1:0] rel;
    logic [SH_W-1:0]  msb;

    // Position of the counter within the shifted window
    always_comb begin
        rel = cnt - off;
        msb = span_sh - SH_W'(1);
    end

    // Register the output level: low half of the window is high
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= ~rel[msb] ^ inv;
    end

endmodule

// File: rtl/skewgen_top.sv
// Four-bank programmable skew clock generator. One counter feeds a
// reference generator and one decode/phase pair per bank; both outputs of
// a bank share one flop. Assumes synchronous active-low reset.
module skewgen_top
    import skewgen_pkg::*;
#(
    parameter int BASE_UNITS = 8,
    localparam int CNT_W     = $clog2(BASE_UNITS) + 4,
    localparam int SH_W      = $clog2(CNT_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              range_sel,
    input  logic [1:0]              edge_sel,
    input  logic [1:0]              test_sel,
    input  logic [BANKS*CODE_W-1:0] bank_code,
    output logic                    ref_out,
    output logic [2*BANKS-1:0]      bank_out
);

    cfg_t             cfg_in;
    cfg_t             cfg_q;
    logic [CNT_W-1:0] cnt;
    logic [SH_W-1:0]  per_sh;

    // Pack raw selects into the configuration word
    always_comb begin
        cfg_in.range_sel = range_sel;
        cfg_in.fall_sync = (edge_sel == 2'b00);
        cfg_in.bypass    = (test_sel != 2'b00);
        cfg_in.codes     = bank_code;
    end

    skewgen_timebase #(
        .BASE_UNITS(BASE_UNITS),
        .CNT_W     (CNT_W),
        .SH_W      (SH_W)
    ) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg_in(cfg_in),
        .cnt   (cnt),
        .cfg_q (cfg_q),
        .per_sh(per_sh)
    );

    skewgen_phase_gen #(.CNT_W(CNT_W), .SH_W(SH_W)) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt    (cnt),
        .off    ('0),
        .span_sh(per_sh),
        .inv    (1'b0),
        .q      (ref_out)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        localparam bank_kind_t KIND = (b < 2) ? KIND_FINE :
                                      (b == 2) ? KIND_DIV4 : KIND_INV;
        logic [CNT_W-1:0] off;
        logic [1:0]       div_sh;
        logic             inv;
        logic [SH_W-1:0]  span_sh;
        logic             q;

        skewgen_bank_decode #(.KIND(KIND), .CNT_W(CNT_W), .SH_W(SH_W)) u_dec (
            .code     (cfg_q.codes[b*CODE_W +: CODE_W]),
            .fall_sync(cfg_q.fall_sync),
            .bypass   (cfg_q.bypass),
            .per_sh   (per_sh),
            .off      (off),
            .div_sh   (div_sh),
            .inv      (inv)
        );

        // Window length exponent: reference period times the divider
        always_comb span_sh = per_sh + SH_W'(div_sh);

        skewgen_phase_gen #(.CNT_W(CNT_W), .SH_W(SH_W)) u_ph (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt    (cnt),
            .off    (off),
            .span_sh(span_sh),
            .inv    (inv),
            .q      (q)
        );

        assign bank_out[2*b]   = q;
        assign bank_out[2*b+1] = q;
    end

    // R1: a reset edge leaves every output low
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> (ref_out == 1'b0 && bank_out == '0));

    // R7: bypassed bank 1 and bank 2 follow the reference
    a_r7_bypass_follow: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.bypass |=> (bank_out[0] == ref_out && bank_out[2] == ref_out));

    // R5: bank 4 in invert mode is the complement of the reference
    a_r5_invert: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.bypass && !cfg_q.fall_sync &&
         code_index(cfg_q.codes[3*CODE_W +: CODE_W]) == 8)
        |=> (bank_out[6] != ref_out));

    // R6: falling-edge sync at zero skew is the complement of the reference
    a_r6_fall_align: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.bypass && cfg_q.fall_sync &&
         code_index(cfg_q.codes[0 +: CODE_W]) == 4)
        |=> (bank_out[0] != ref_out));

endmodule

// File: tb/sim_skewgen_top.sv
module sim_skewgen_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rng = 2'b10;
    logic [1:0]  edg = 2'b10;
    logic [1:0]  tst = 2'b00;
    logic [15:0] codes = 16'h5555;
    logic        ref_out;
    logic [7:0]  bank_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model state
    int          mcnt = 0;
    logic [1:0]  m_rng, m_edg, m_tst;
    logic [15:0] m_codes;
    logic        m_ref = 1'b0;
    logic [7:0]  m_bank = '0;

    // Current mismatch tracking for one check window
    int          bad;
    logic [8:0]  first_act, first_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    skewgen_top u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .range_sel(rng),
        .edge_sel (edg),
        .test_sel (tst),
        .bank_code(codes),
        .ref_out  (ref_out),
        .bank_out (bank_out)
    );

    // Vector: {range, edge, test, codes, requirement number}
    localparam logic [25:0] VEC [NVEC] = '{
        {2'b10, 2'b10, 2'b00, 16'h5555, 4'd2},  // R2 range H, all zero skew
        {2'b01, 2'b01, 2'b00, 16'h55A0, 4'd3},  // R3 -4 and +4 at range M
        {2'b00, 2'b10, 2'b00, 16'h5591, 4'd3},  // R3 -3 and +3 at range L
        {2'b10, 2'b10, 2'b00, 16'h557F, 4'd3},  // R3 digit 11 read as mid
        {2'b10, 2'b10, 2'b00, 16'h9055, 4'd4},  // R4 bank 3 divide by 2
        {2'b01, 2'b10, 2'b00, 16'h1A55, 4'd4},  // R4 bank 3 divide by 4
        {2'b10, 2'b10, 2'b00, 16'h8155, 4'd4},  // R4 bank 3 -6, bank 4 +4
        {2'b10, 2'b10, 2'b00, 16'hA555, 4'd5},  // R5 bank 4 inverted
        {2'b00, 2'b01, 2'b00, 16'h0455, 4'd5},  // R5 bank 4 divide by 2
        {2'b01, 2'b00, 2'b00, 16'h5555, 4'd6},  // R6 falling-edge sync
        {2'b10, 2'b00, 2'b00, 16'hA0A6, 4'd6},  // R6 falling edge with skews
        {2'b10, 2'b00, 2'b01, 16'hA0A6, 4'd7},  // R7 bypass, edge ignored
        {2'b01, 2'b10, 2'b10, 16'h0A19, 4'd7},  // R7 bypass dividers
        {2'b11, 2'b10, 2'b00, 16'h5A60, 4'd2}   // R2 range 11 read as mid
    };

    function automatic int nrm(input logic [1:0] d);
        return (d == 2'b11) ? 1 : int'(d);
    endfunction

    function automatic int per_of(input logic [1:0] r);
        case (nrm(r))
            0:       return 32;
            1:       return 16;
            default: return 8;
        endcase
    endfunction

    // Expected level of bank b at counter value m under the given settings
    function automatic logic exp_bank(input int b, input int m,
                                      input logic [1:0] r, input logic [1:0] e,
                                      input logic [1:0] t, input logic [15:0] c);
        int p, idx, s, sh, dv, len, ph;
        logic iv;
        logic [3:0] cd;
        p  = per_of(r);
        cd = c[b*4 +: 4];
        idx = nrm(cd[3:2]) * 3 + nrm(cd[1:0]);
        s = 0; sh = 0; dv = 1; iv = 1'b0;
        if (t != 2'b00) begin
            if (b == 2) dv = (idx == 0) ? 2 : (idx == 8) ? 4 : 1;
            if (b == 3) dv = (idx == 0) ? 2 : 1;
        end else begin
            sh = (e == 2'b00) ? p / 2 : 0;
            if (b < 2)          s = idx - 4;
            else if (idx == 0)  dv = 2;
            else if (idx == 8) begin
                if (b == 2) dv = 4;
                else        iv = 1'b1;
            end else            s = 2 * (idx - 4);
        end
        len = dv * p;
        ph  = ((m - s - sh) % len + len) % len;
        return (ph < len / 2) ^ iv;
    endfunction

    // Advance one clock, update the model, compare a quarter period later
    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            mcnt = 0;
            m_rng = rng; m_edg = edg; m_tst = tst; m_codes = codes;
            m_ref = 1'b0; m_bank = '0;
        end else begin
            int p;
            p = per_of(m_rng);
            m_ref = ((mcnt % p) < p / 2);
            for (int b = 0; b < 4; b++) begin
                m_bank[2*b]   = exp_bank(b, mcnt, m_rng, m_edg, m_tst, m_codes);
                m_bank[2*b+1] = m_bank[2*b];
            end
            if (mcnt == 4 * p - 1) begin
                mcnt = 0;
                m_rng = rng; m_edg = edg; m_tst = tst; m_codes = codes;
            end else begin
                mcnt++;
            end
        end
        #(CLK_PERIOD/4);
        if ({ref_out, bank_out} !== {m_ref, m_bank}) begin
            if (bad == 0) begin
                first_act = {ref_out, bank_out};
                first_exp = {m_ref, m_bank};
            end
            bad++;
        end
    endtask

    task automatic close_check(input string tag);
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s: {ref,banks} actual %b expected %b (%0d cycles off)",
                     tag, first_act, first_exp, bad);
        end
        bad = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    initial begin
        bad = 0;
        // R1: outputs low while in reset, after outputs have been active
        do_reset();
        repeat (20) step();
        rst_n = 1'b0;
        step();
        checks++;
        if ({ref_out, bank_out} !== 9'b0) begin
            fails++;
            $display("FAIL R1: {ref,banks} actual %b expected %b",
                     {ref_out, bank_out}, 9'b0);
        end
        bad = 0;

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            {rng, edg, tst, codes} = VEC[i][25:4];
            do_reset();
            for (int k = 0; k < 2 * 4 * per_of(rng); k++) step();
            close_check($sformatf("R%0d vector %0d", VEC[i][3:0], i));
        end

        // R8: mid-window change must wait for the counter wrap
        rng = 2'b10; edg = 2'b10; tst = 2'b00; codes = 16'h5555;
        do_reset();
        repeat (10) step();
        rng = 2'b00; edg = 2'b00; codes = 16'h5590;
        repeat (3 * 128) step();
        close_check("R8 change applied at wrap only");

        // R9: 50% duty and identical pair on bank 1 over one range-L period
        begin
            int hi0, hi1, diff;
            rng = 2'b00; edg = 2'b10; tst = 2'b00; codes = 16'h5556;
            do_reset();
            repeat (5) step();
            hi0 = 0; hi1 = 0; diff = 0;
            for (int k = 0; k < 32; k++) begin
                step();
                hi0 += int'(bank_out[0]);
                hi1 += int'(bank_out[1]);
                if (bank_out[0] != bank_out[1]) diff++;
            end
            checks++;
            if (hi0 != 16 || hi1 != 16 || diff != 0) begin
                fails++;
                $display("FAIL R9: high counts %0d/%0d mismatches %0d expected 16/16 0",
                         hi0, hi1, diff);
            end
            bad = 0;
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule